// File: doc/BRIEF.md
# Dual-Bank Flash Operation Tracker

This block watches a flash array split into two banks and decides, one request at a time, whether a read, program, block erase, erase suspend or erase resume may proceed. It decodes a 21-bit word address into a bank and a block index. It keeps one small state machine per bank. It answers every request with a one-cycle accept or reject pulse. It also shows which banks are busy, which hold a suspended erase, and which block each suspended erase belongs to. The program/erase engine sits outside the block and reports each finished operation on a per-bank done pulse.

Bank A (index 0) is the small bank. It holds the eight 4-KWord parameter blocks and fifteen 32-KWord main blocks. Bank B (index 1) holds forty-eight 32-KWord main blocks. The parameter `PARAM_AT_TOP` puts bank A and its parameter blocks at the high end of the address space. When it is 0 (the default), they sit at the low end. Each bank state machine has five states. IDLE moves to PROG on an accepted program and to ERASE on an accepted erase. PROG moves back to IDLE on done. ERASE moves to IDLE on done and to SUSP on an accepted suspend. SUSP moves to SUSP_PROG on an accepted program to another block and back to ERASE on resume. SUSP_PROG moves back to SUSP on done.

Top module: `dual_bank_tracker`

## Requirements
- R1: During and after reset, `ack`, `nak`, `bank_busy` and `erase_susp` are all 0.
- R2: With `PARAM_AT_TOP`=0, word addresses below 0x080000 are bank A. Blocks 0..7 are the parameter blocks at 0x000000-0x007FFF, at 0x1000 words each. Above 0x007FFF the block number is addr[20:15]+7. With `PARAM_AT_TOP`=1, bank A is 0x180000 and above. Parameter blocks 63..70 are 63+addr[14:12] at 0x1F8000-0x1FFFFF. Elsewhere the block number is addr[20:15]. The block index is visible through `susp_blk_a`/`susp_blk_b`.
- R3: A program (cmd 2) or erase (cmd 3) to an idle bank is accepted. That bank's `bank_busy` bit goes to 1 and stays there until `pe_done` for that bank returns it to 0.
- R4: A read (cmd 1) to a bank whose `bank_busy` bit is 1 is rejected. A read to an idle bank is accepted.
- R5: While one bank is busy, a read to the other bank is accepted, provided that bank is idle or holds a suspended erase of a different block.
- R6: A program or erase to a bank that is busy or holds a suspended erase is rejected, and that bank's state is unchanged. The one exception is a program to a different block in a suspended bank (see R8).
- R7: An erase suspend (cmd 4) is accepted only while its bank is erasing. After it, `bank_busy` for that bank is 0, `erase_susp` is 1, and the suspend block output shows the erased block. A suspend in any other state is rejected.
- R8: While an erase is suspended, reads and programs to other blocks of the same bank are accepted. A program makes the bank busy until done, after which the bank returns to the suspended state. Reads and programs aimed at the suspended block are rejected.
- R9: An erase resume (cmd 5) to a suspended, non-busy bank is accepted and restores the erase on the same block. A resume to a bank with no suspended erase is rejected and changes nothing.
- R10: Command code 0 is no request and produces no pulse. Codes 6 and 7 are reserved and are rejected.
- R11: A `pe_done` pulse to a bank that is idle or suspended has no effect. A done pulse that arrives in the same cycle as a suspend to an erasing bank wins: the erase ends and the suspend is rejected.
- R12: Exactly one of `ack`/`nak` pulses in the cycle after each request, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Request code: 0 none, 1 read, 2 program, 3 erase, 4 suspend, 5 resume |
| addr | input | 21 | Word address of the request |
| pe_done | input | 2 | Per-bank operation-finished pulse from the engine |
| ack | output | 1 | Request accepted (one cycle after request) |
| nak | output | 1 | Request rejected (one cycle after request) |
| bank_busy | output | 2 | Bank is programming or erasing |
| erase_susp | output | 2 | Bank holds a suspended erase |
| susp_blk_a | output | 7 | Block index of bank A's erase in progress or suspended |
| susp_blk_b | output | 7 | Block index of bank B's erase in progress or suspended |

## Verification
A request is sampled at a rising edge, and its `ack` or `nak` pulse appears after that same edge. The bank flags and block indices change after that edge too, as does the effect of a `pe_done` pulse. The scoreboard monitor samples one time unit after each rising edge. At that point the request that was just sampled is still on `cmd`, so the monitor pops the matching expected answer. Directed flag checks run at the following falling edge, a full half-period after the registers have settled.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_READ    = 3'd1,
        OP_PROG    = 3'd2,
        OP_ERASE   = 3'd3,
        OP_SUSPEND = 3'd4,
        OP_RESUME  = 3'd5
    } fbt_op_e;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_PROG,
        BK_ERASE,
        BK_SUSP,
        BK_SUSP_PROG
    } bk_state_e;

endpackage

// File: rtl/fbt_addr_decode.sv
module fbt_addr_decode #(
    parameter int ADDR_W       = 21,
    parameter int MAIN_W       = 15,
    parameter int PARAM_W      = 12,
    parameter int BANK_A_UNITS = 16,
    parameter bit PARAM_AT_TOP = 1'b0,
    parameter int BLK_W        = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank,
    output logic [BLK_W-1:0]  blk
);
    localparam int IDX_W      = ADDR_W - MAIN_W;
    localparam int SUB_W      = MAIN_W - PARAM_W;
    localparam int N_UNITS    = 1 << IDX_W;
    localparam int N_PARAM    = 1 << SUB_W;
    localparam int N_MAIN_ALL = N_UNITS - 1;

    logic [IDX_W-1:0] idx;
    logic [SUB_W-1:0] sub;
    logic             is_param;

    assign idx = addr[ADDR_W-1:MAIN_W];
    assign sub = addr[MAIN_W-1:PARAM_W];

    generate
        if (PARAM_AT_TOP) begin : g_top
            always_comb begin
                is_param = (idx == IDX_W'(N_UNITS - 1));
                bank     = !(idx >= IDX_W'(N_UNITS - BANK_A_UNITS));
                if (is_param) blk = BLK_W'(N_MAIN_ALL) + BLK_W'(sub);
                else          blk = BLK_W'(idx);
            end
        end else begin : g_bottom
            always_comb begin
                is_param = (idx == '0);
                bank     = !(idx < IDX_W'(BANK_A_UNITS));
                if (is_param) blk = BLK_W'(sub);
                else          blk = BLK_W'(idx) + BLK_W'(N_PARAM - 1);
            end
        end
    endgenerate

endmodule

// File: rtl/fbt_bank_ctrl.sv
module fbt_bank_ctrl
    import fbt_pkg::*;
#(
    parameter int BLK_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  fbt_op_e          op,
    input  logic [BLK_W-1:0] blk,
    input  logic             done,
    output logic             accept,
    output logic             busy,
    output logic             susp,
    output logic [BLK_W-1:0] erase_blk
);
    bk_state_e        state, state_d;
    logic [BLK_W-1:0] erase_blk_d;

    // next state and accept decision
    always_comb begin
        state_d     = state;
        erase_blk_d = erase_blk;
        accept      = 1'b0;
        unique case (state)
            BK_IDLE: begin
                if (sel) begin
                    if (op == OP_READ) begin
                        accept = 1'b1;
                    end else if (op == OP_PROG) begin
                        accept  = 1'b1;
                        state_d = BK_PROG;
                    end else if (op == OP_ERASE) begin
                        accept      = 1'b1;
                        state_d     = BK_ERASE;
                        erase_blk_d = blk;
                    end
                end
            end
            BK_PROG: begin
                if (done) state_d = BK_IDLE;
            end
            BK_ERASE: begin
                if (done) begin
                    state_d = BK_IDLE;
                end else if (sel && op == OP_SUSPEND) begin
                    accept  = 1'b1;
                    state_d = BK_SUSP;
                end
            end
            BK_SUSP: begin
                if (sel) begin
                    if (op == OP_READ && blk != erase_blk) begin
                        accept = 1'b1;
                    end else if (op == OP_PROG && blk != erase_blk) begin
                        accept  = 1'b1;
                        state_d = BK_SUSP_PROG;
                    end else if (op == OP_RESUME) begin
                        accept  = 1'b1;
                        state_d = BK_ERASE;
                    end
                end
            end
            BK_SUSP_PROG: begin
                if (done) state_d = BK_SUSP;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BK_IDLE;
            erase_blk <= '0;
        end else begin
            state     <= state_d;
            erase_blk <= erase_blk_d;
        end
    end

    // outputs from state
    always_comb begin
        busy = 1'b0;
        susp = 1'b0;
        unique case (state)
            BK_IDLE:      ;
            BK_PROG:      busy = 1'b1;
            BK_ERASE:     busy = 1'b1;
            BK_SUSP:      susp = 1'b1;
            BK_SUSP_PROG: begin busy = 1'b1; susp = 1'b1; end
            default:      ;
        endcase
    end

    // R9: resume continues the erase on the block that was suspended
    a_r9_resume_same_blk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_ERASE && $past(state) == BK_SUSP) |-> erase_blk == $past(erase_blk));

    // R8: suspended block index holds while the erase is suspended
    a_r8_susp_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && $past(susp) && $past(rst_n)) |-> $stable(erase_blk));

    // R11: done to an idle bank leaves it idle unless a new request starts it
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BK_IDLE && done && !sel) |=> state == BK_IDLE);

endmodule

// File: rtl/dual_bank_tracker.sv
module dual_bank_tracker
    import fbt_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int MAIN_W       = 15,
    parameter int PARAM_W      = 12,
    parameter int BANK_A_UNITS = 16,
    parameter bit PARAM_AT_TOP = 1'b0,
    parameter int N_BANKS      = 2,
    parameter int BLK_W        = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        pe_done,
    output logic              ack,
    output logic              nak,
    output logic [1:0]        bank_busy,
    output logic [1:0]        erase_susp,
    output logic [BLK_W-1:0]  susp_blk_a,
    output logic [BLK_W-1:0]  susp_blk_b
);
    localparam int N_BLK = (1 << (ADDR_W - MAIN_W)) - 1 + (1 << (MAIN_W - PARAM_W));

    fbt_op_e          op;
    logic             op_valid;
    logic             dec_bank;
    logic [BLK_W-1:0] dec_blk;
    logic [N_BANKS-1:0] acc_vec;
    logic [BLK_W-1:0] eblk [N_BANKS];
    logic             acc_sel;

    assign op       = fbt_op_e'(cmd);
    assign op_valid = (cmd >= 3'd1) && (cmd <= 3'd5);

    fbt_addr_decode #(
        .ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
        .BANK_A_UNITS(BANK_A_UNITS), .PARAM_AT_TOP(PARAM_AT_TOP), .BLK_W(BLK_W)
    ) u_dec (
        .addr(addr), .bank(dec_bank), .blk(dec_blk)
    );

    generate
        for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
            fbt_bank_ctrl #(.BLK_W(BLK_W)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .sel(op_valid && (dec_bank == b[0])),
                .op(op), .blk(dec_blk), .done(pe_done[b]),
                .accept(acc_vec[b]), .busy(bank_busy[b]),
                .susp(erase_susp[b]), .erase_blk(eblk[b])
            );
        end
    endgenerate

    assign acc_sel    = acc_vec[dec_bank];
    assign susp_blk_a = eblk[0];
    assign susp_blk_b = eblk[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            nak <= 1'b0;
        end else begin
            ack <= op_valid && acc_sel;
            nak <= (cmd != 3'd0) && !(op_valid && acc_sel);
        end
    end

    // R12: never both pulses
    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n) !(ack && nak));
    // R10: idle code gives no pulse; reserved codes are rejected
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd0) |=> (!ack && !nak));
    a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd > 3'd5) |=> nak);
    // R4: read to a busy bank is rejected
    a_r4_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && bank_busy[dec_bank]) |=> nak);
    // R5: read to a quiet bank is accepted regardless of the other bank
    a_r5_free_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && !bank_busy[dec_bank] && !erase_susp[dec_bank]) |=> ack);
    // R6: second program or erase to a busy bank is rejected
    a_r6_busy_pe: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_PROG || op == OP_ERASE) && bank_busy[dec_bank]) |=> nak);
    // R8: requests aimed at the suspended block are rejected
    a_r8_self_blk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_READ || op == OP_PROG) && erase_susp[dec_bank] &&
         dec_blk == eblk[dec_bank]) |=> nak);
    // R9: resume with nothing suspended is rejected and changes nothing
    a_r9_resume_none: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESUME && !erase_susp[dec_bank] && pe_done == 2'b00) |=> (nak && $stable(bank_busy)));
    // R2: decoded block index stays inside the array
    a_r2_blk_range: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (int'(dec_blk) < N_BLK));

endmodule

// File: tb/sim_dual_bank_tracker.sv
`timescale 1ns/100ps
module sim_dual_bank_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [20:0] addr = '0;
    logic [1:0]  pe_done = 2'b00;
    logic        ack, nak;
    logic [1:0]  bank_busy, erase_susp;
    logic [6:0]  susp_blk_a, susp_blk_b;

    logic [2:0]  c1 = 3'd0;
    logic [20:0] a1 = '0;
    logic        ack1, nak1;
    logic [1:0]  busy1, susp1;
    logic [6:0]  sba1, sbb1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit    q_ack[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    dual_bank_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .pe_done(pe_done),
        .ack(ack), .nak(nak), .bank_busy(bank_busy), .erase_susp(erase_susp),
        .susp_blk_a(susp_blk_a), .susp_blk_b(susp_blk_b)
    );

    dual_bank_tracker #(.PARAM_AT_TOP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd(c1), .addr(a1), .pe_done(2'b00),
        .ack(ack1), .nak(nak1), .bank_busy(busy1), .erase_susp(susp1),
        .susp_blk_a(sba1), .susp_blk_b(sbb1)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one request for one cycle, expected answer pushed to scoreboard
    task automatic issue(input logic [2:0] c, input logic [20:0] a,
                         input bit exp_ack, input logic [1:0] dn, input string tag);
        @(negedge clk);
        cmd = c; addr = a; pe_done = dn;
        q_ack.push_back(exp_ack);
        q_tag.push_back(tag);
        @(negedge clk);
        cmd = 3'd0; pe_done = 2'b00;
    endtask

    task automatic done_pulse(input logic [1:0] dn);
        @(negedge clk);
        pe_done = dn;
        @(negedge clk);
        pe_done = 2'b00;
    endtask

    // monitor: compare each response one unit after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && cmd != 3'd0 && q_ack.size() > 0) begin
                bit    e;
                string t;
                e = q_ack.pop_front();
                t = q_tag.pop_front();
                chk(int'({ack, nak}), e ? 2 : 1, t);
            end else if (rst_n && cmd == 3'd0 && (ack || nak)) begin
                chk(int'({ack, nak}), 0, "R10 idle pulse");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [2:0] RD = 3'd1, PG = 3'd2, ER = 3'd3, SU = 3'd4, RS = 3'd5;
    localparam logic [20:0] A_P0 = 21'h000000, A_P3 = 21'h003000, A_M = 21'h010000;
    localparam logic [20:0] B_M = 21'h100000, B_M2 = 21'h180000;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int'({ack, nak}), 0, "R1 pulses in reset");
        chk(int'(bank_busy), 0, "R1 busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(erase_susp), 0, "R1 susp after reset");

        issue(RD, A_P0, 1, 2'b00, "R4 read idle A");
        issue(RD, B_M, 1, 2'b00, "R4 read idle B");
        issue(PG, A_M, 1, 2'b00, "R3 program A");
        chk(int'(bank_busy), 1, "R3 busy A");
        issue(RD, A_P0, 0, 2'b00, "R4 read busy A");
        issue(RD, B_M, 1, 2'b00, "R5 read B while A busy");
        issue(PG, A_P0, 0, 2'b00, "R6 second program A");
        issue(ER, A_M, 0, 2'b00, "R6 erase busy A");
        issue(PG, B_M2, 1, 2'b00, "R3 program B");
        chk(int'(bank_busy), 3, "R3 both busy");
        done_pulse(2'b01);
        chk(int'(bank_busy), 2, "R3 done A");
        done_pulse(2'b10);
        chk(int'(bank_busy), 0, "R3 done B");

        issue(3'd6, A_P0, 0, 2'b00, "R10 reserved 6");
        issue(3'd7, B_M, 0, 2'b00, "R10 reserved 7");
        issue(RS, A_P0, 0, 2'b00, "R9 resume nothing");
        chk(int'({bank_busy, erase_susp}), 0, "R9 resume no change");
        issue(SU, A_P0, 0, 2'b00, "R7 suspend idle");
        done_pulse(2'b01);
        chk(int'(bank_busy), 0, "R11 done while idle");

        issue(ER, A_P3, 1, 2'b00, "R3 erase A");
        chk(int'(bank_busy), 1, "R3 erase busy");
        issue(SU, A_P0, 1, 2'b00, "R7 suspend A");
        chk(int'({bank_busy, erase_susp}), 1, "R7 flags after suspend");
        chk(int'(susp_blk_a), 3, "R2 param block 3");
        issue(RD, A_P3, 0, 2'b00, "R8 read suspended blk");
        issue(RD, A_P0, 1, 2'b00, "R8 read other blk");
        issue(PG, A_P3, 0, 2'b00, "R8 program suspended blk");
        issue(ER, A_P0, 0, 2'b00, "R6 erase while suspended");
        issue(PG, A_P0, 1, 2'b00, "R8 program other blk");
        chk(int'({bank_busy, erase_susp}), 5, "R8 busy while suspended");
        issue(RD, A_M, 0, 2'b00, "R4 read during suspend-program");
        issue(RS, A_P0, 0, 2'b00, "R9 resume while busy");
        done_pulse(2'b01);
        chk(int'({bank_busy, erase_susp}), 1, "R8 back to suspended");
        done_pulse(2'b01);
        chk(int'({bank_busy, erase_susp}), 1, "R11 done while suspended");
        issue(RS, A_M, 1, 2'b00, "R9 resume A");
        chk(int'({bank_busy, erase_susp}), 4, "R9 erase again");
        issue(SU, A_M, 1, 2'b00, "R9 suspend again");
        chk(int'(susp_blk_a), 3, "R9 same block kept");
        issue(RS, A_M, 1, 2'b00, "R9 resume again");
        done_pulse(2'b01);
        chk(int'(bank_busy), 0, "R3 erase done");

        issue(ER, B_M, 1, 2'b00, "R3 erase B");
        issue(SU, B_M2, 1, 2'b00, "R7 suspend B");
        chk(int'(susp_blk_b), 39, "R2 main block 39");
        issue(RD, A_M, 1, 2'b00, "R5 read A with B suspended");
        issue(RS, B_M, 1, 2'b00, "R9 resume B");
        issue(SU, B_M, 0, 2'b10, "R11 done beats suspend");
        chk(int'({bank_busy, erase_susp}), 0, "R11 erase ended");

        // R2 top-placed parameter blocks on u1
        @(negedge clk); c1 = ER; a1 = 21'h1FF000;
        @(negedge clk); c1 = 3'd0;
        chk(int'(ack1), 1, "R2 top erase ack");
        @(negedge clk); c1 = SU;
        @(negedge clk); c1 = 3'd0;
        chk(int'(sba1), 70, "R2 top param block 70");
        @(negedge clk); c1 = ER; a1 = 21'h000000;
        @(negedge clk); c1 = 3'd0;
        @(negedge clk); c1 = SU;
        @(negedge clk); c1 = 3'd0;
        chk(int'({susp1, sbb1}), 3 << 7, "R2 top bank B block 0");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule